// File: doc/BRIEF.md
# Network Time-Code Port

This block is the time distribution end point of a packet router. A local tick input asks it to broadcast a time-code toward a link. A configuration bit selects where the code comes from. It can come from the block's own counter, which steps once per tick. It can also come from a value that an outside source presents on an input bus. The link encoder receives a one-cycle send request together with the 8-bit code.

In the other direction, the link reports each time-code it receives from the network. The block keeps a running count. A received code is accepted as the genuine next time only when its count field is one more than the stored count. In that case the block raises a one-cycle tick output and shows the code on an output bus. Any other code resynchronises the stored count without a tick output. The stored count is always visible on a status port.

Top module: `timecode_port`

## Requirements
- R1: While `rstN` is low, `curCount`, `sendCode` and `timeOut` are all zero, and `sendReq` and `tickOut` are low.
- R2: A time-code is 8 bits, with the count in bits [5:0] and the two flags in bits [7:6]. With `extMode`=0, a cycle with `tickIn` high advances `curCount` by one. In the cycle after, `sendReq` is high and `sendCode` holds flags 00 with the new count.
- R3: The count wraps. A local step from 63 gives 0, and a received count of 0 is the valid successor of a stored 63.
- R4: With `extMode`=1, a cycle with `tickIn` high puts the value of `extCode` from that cycle on `sendCode` in the next cycle, with `sendReq` high. `curCount` takes bits [5:0] of `extCode`.
- R5: When `rxValid` is high and bits [5:0] of `rxCode` equal `curCount`+1 modulo 64, the following happens in the next cycle. `tickOut` is high for that one cycle, `timeOut` equals `rxCode` including its flags, and `curCount` equals bits [5:0] of `rxCode`.
- R6: When `rxValid` is high and the count does not match, `curCount` takes the received count. `tickOut` stays low and `timeOut` keeps its previous value.
- R7: `timeOut` and `sendCode` hold their values in any cycle without an accepted received code or a send, respectively.
- R8: When `tickIn` and `rxValid` are high in the same cycle, the received code is discarded. The tick is served, and no `tickOut` follows.
- R9: A change of `extMode` alone sends nothing and leaves `curCount` unchanged. The new mode applies from the next tick.
- R10: `sendReq` is high for exactly one cycle per `tickIn` cycle, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extMode | input | 1 | Source select for sent codes: 0 = own counter, 1 = `extCode` |
| tickIn | input | 1 | Local tick request, one cycle per tick |
| extCode | input | 8 | Externally supplied time-code |
| rxValid | input | 1 | Link reports a received time-code this cycle |
| rxCode | input | 8 | Received time-code |
| sendReq | output | 1 | One-cycle request to the link to send `sendCode` |
| sendCode | output | 8 | Time-code to send |
| tickOut | output | 1 | One-cycle pulse: a valid time-code was received |
| timeOut | output | 8 | Last valid received time-code |
| curCount | output | 6 | Current time count, for status readback |

## Verification
The bench builds the block with its default widths: a 6-bit count and 2 flag bits. With these widths the full count range is short enough to step through completely. The run drives the counter across the 63-to-0 boundary both by local ticks and by a received successor code. The 2 flag bits make it possible to show that flags travel on the output bus but take no part in the match.

// File: rtl/tcport_pkg.sv
package tcport_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic stepCnt;  // internal source: advance counter and send
    logic loadExt;  // external source: send outside value
    logic loadRx;   // received code takes the counter
    logic pubRx;    // received code is the expected successor
  } tcStrobe_t;

endpackage

// File: rtl/tcport_ctrl.sv
module tcport_ctrl
  import tcport_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickIn,
  input  logic      extMode,
  input  logic      rxValid,
  input  logic      rxMatch,
  output tcStrobe_t strobe,
  output logic      sendReq,
  output logic      tickOut
);

  // A local tick always wins over a received code in the same cycle
  always_comb begin
    strobe.stepCnt = tickIn & ~extMode;
    strobe.loadExt = tickIn & extMode;
    strobe.loadRx  = rxValid & ~tickIn;
    strobe.pubRx   = rxValid & ~tickIn & rxMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendReq <= 1'b0;
      tickOut <= 1'b0;
    end else begin
      sendReq <= strobe.stepCnt | strobe.loadExt;
      tickOut <= strobe.pubRx;
    end
  end

endmodule

// File: rtl/tcport_datapath.sv
module tcport_datapath
  import tcport_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FLAG_W = 2,
  localparam int CODE_W = CNT_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcStrobe_t         strobe,
  input  logic [CODE_W-1:0] extCode,
  input  logic [CODE_W-1:0] rxCode,
  output logic              rxMatch,
  output logic [CODE_W-1:0] sendCode,
  output logic [CODE_W-1:0] timeOut,
  output logic [CNT_W-1:0]  curCount
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] nextCnt;

  assign nextCnt = curCount + ONE;   // wraps naturally at 2**CNT_W
  assign rxMatch = (rxCode[CNT_W-1:0] == nextCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount <= '0;
      sendCode <= '0;
    end else if (strobe.stepCnt) begin
      curCount <= nextCnt;
      sendCode <= {{FLAG_W{1'b0}}, nextCnt};
    end else if (strobe.loadExt) begin
      curCount <= extCode[CNT_W-1:0];
      sendCode <= extCode;
    end else if (strobe.loadRx) begin
      curCount <= rxCode[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timeOut <= '0;
    else if (strobe.pubRx) timeOut <= rxCode;
  end

endmodule

// File: rtl/timecode_port.sv
module timecode_port
  import tcport_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FLAG_W = 2,
  localparam int CODE_W = CNT_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMode,
  input  logic              tickIn,
  input  logic [CODE_W-1:0] extCode,
  input  logic              rxValid,
  input  logic [CODE_W-1:0] rxCode,
  output logic              sendReq,
  output logic [CODE_W-1:0] sendCode,
  output logic              tickOut,
  output logic [CODE_W-1:0] timeOut,
  output logic [CNT_W-1:0]  curCount
);

  tcStrobe_t strobe;
  logic      rxMatch;

  tcport_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .extMode (extMode),
    .rxValid (rxValid),
    .rxMatch (rxMatch),
    .strobe  (strobe),
    .sendReq (sendReq),
    .tickOut (tickOut)
  );

  tcport_datapath #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .extCode  (extCode),
    .rxCode   (rxCode),
    .rxMatch  (rxMatch),
    .sendCode (sendCode),
    .timeOut  (timeOut),
    .curCount (curCount)
  );

endmodule

// File: rtl/timecode_port_chk.sv
module timecode_port_chk #(
  parameter int CNT_W  = 6,
  parameter int FLAG_W = 2,
  localparam int CODE_W = CNT_W + FLAG_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              extMode,
  input logic              tickIn,
  input logic [CODE_W-1:0] extCode,
  input logic              rxValid,
  input logic [CODE_W-1:0] rxCode,
  input logic              sendReq,
  input logic [CODE_W-1:0] sendCode,
  input logic              tickOut,
  input logic [CODE_W-1:0] timeOut,
  input logic [CNT_W-1:0]  curCount
);

  // R2: an internal send carries zero flags and the new count
  a_r2_internal_send: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !$past(extMode)) |-> (sendCode == {{FLAG_W{1'b0}}, curCount}));

  // R3: local step from all-ones gives zero
  a_r3_local_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tickIn) && !$past(extMode) && ($past(curCount) == '1)) |-> (curCount == '0));

  // R4: an external send copies the outside value
  a_r4_external_send: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && $past(extMode)) |->
      (sendCode == $past(extCode) && curCount == $past(extCode[CNT_W-1:0])));

  // R5: tick output presents the received code
  a_r5_tick_value: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> (timeOut == $past(rxCode) && curCount == $past(rxCode[CNT_W-1:0])));

  // R5: tick output only follows a received code
  a_r5_tick_cause: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(rxValid));

  // R7: output bus holds without a received code
  a_r7_hold_time: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxValid) |-> $stable(timeOut));

  // R8: a simultaneous tick discards the received code
  a_r8_tick_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tickIn) && $past(rxValid)) |-> !tickOut);

  // R10: every tick produces a send request, and only a tick does
  a_r10_send_per_tick: assert property (@(posedge clk) disable iff (!rstN)
    $past(tickIn) |-> sendReq);
  a_r10_send_cause: assert property (@(posedge clk) disable iff (!rstN)
    sendReq |-> $past(tickIn));

endmodule

bind timecode_port timecode_port_chk #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .extMode  (extMode),
  .tickIn   (tickIn),
  .extCode  (extCode),
  .rxValid  (rxValid),
  .rxCode   (rxCode),
  .sendReq  (sendReq),
  .sendCode (sendCode),
  .tickOut  (tickOut),
  .timeOut  (timeOut),
  .curCount (curCount)
);

// File: tb/timecode_port_bench.sv
`timescale 1ns/1ps
module timecode_port_bench;

  localparam int CNT_W  = 6;
  localparam int FLAG_W = 2;
  localparam int CODE_W = CNT_W + FLAG_W;

  typedef struct packed {
    logic [7:0] req;
    logic       tk;
    logic       md;
    logic [7:0] ec;
    logic       rv;
    logic [7:0] rc;
    logic       sr;
    logic [7:0] sc;
    logic       to;
    logic [7:0] tout;
    logic [5:0] cnt;
  } vec_t;

  // req, tick, mode, extCode, rxValid, rxCode -> sendReq, sendCode, tickOut, timeOut, count
  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'd2,  1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 8'h00, 6'd1},  // R2 internal tick
    '{8'd10, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 8'h00, 6'd1},  // R10 no tick, no send
    '{8'd5,  1'b0, 1'b0, 8'h00, 1'b1, 8'h42, 1'b0, 8'h01, 1'b1, 8'h42, 6'd2},  // R5 valid successor
    '{8'd7,  1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 8'h42, 6'd2},  // R7 hold, pulse over
    '{8'd6,  1'b0, 1'b0, 8'h00, 1'b1, 8'h07, 1'b0, 8'h01, 1'b0, 8'h42, 6'd7},  // R6 mismatch resyncs
    '{8'd5,  1'b0, 1'b0, 8'h00, 1'b1, 8'h88, 1'b0, 8'h01, 1'b1, 8'h88, 6'd8},  // R5 flags carried
    '{8'd5,  1'b0, 1'b0, 8'h00, 1'b1, 8'h09, 1'b0, 8'h01, 1'b1, 8'h09, 6'd9},  // R5 back to back
    '{8'd9,  1'b0, 1'b1, 8'hC5, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 8'h09, 6'd9},  // R9 mode alone
    '{8'd4,  1'b1, 1'b1, 8'hE3, 1'b0, 8'h00, 1'b1, 8'hE3, 1'b0, 8'h09, 6'd35}, // R4 external tick
    '{8'd8,  1'b1, 1'b1, 8'h10, 1'b1, 8'h24, 1'b1, 8'h10, 1'b0, 8'h09, 6'd16}, // R8 tick beats rx
    '{8'd9,  1'b1, 1'b0, 8'h77, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 8'h09, 6'd17}, // R9 back to internal
    '{8'd5,  1'b0, 1'b0, 8'h00, 1'b1, 8'h12, 1'b0, 8'h11, 1'b1, 8'h12, 6'd18}, // R5
    '{8'd5,  1'b0, 1'b0, 8'h00, 1'b1, 8'hD3, 1'b0, 8'h11, 1'b1, 8'hD3, 6'd19}  // R5 flags ignored in match
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              extMode = 1'b0;
  logic              tickIn = 1'b0;
  logic [CODE_W-1:0] extCode = '0;
  logic              rxValid = 1'b0;
  logic [CODE_W-1:0] rxCode = '0;
  logic              sendReq;
  logic [CODE_W-1:0] sendCode;
  logic              tickOut;
  logic [CODE_W-1:0] timeOut;
  logic [CNT_W-1:0]  curCount;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  timecode_port #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_timecode_port (
    .clk(clk), .rstN(rstN), .extMode(extMode), .tickIn(tickIn),
    .extCode(extCode), .rxValid(rxValid), .rxCode(rxCode),
    .sendReq(sendReq), .sendCode(sendCode), .tickOut(tickOut),
    .timeOut(timeOut), .curCount(curCount)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs from a negedge, then return at the next negedge
  task automatic apply(input logic tk, input logic md, input logic [7:0] ec,
                       input logic rv, input logic [7:0] rc);
    tickIn = tk; extMode = md; extCode = ec; rxValid = rv; rxCode = rc;
    @(posedge clk);
    @(negedge clk);
    tickIn = 1'b0; rxValid = 1'b0;
  endtask

  task automatic checkAll(input string req, input logic sr, input logic [7:0] sc,
                          input logic to, input logic [7:0] tout, input logic [5:0] cnt);
    check(req, "sendReq",  32'(sendReq),  32'(sr));
    check(req, "sendCode", 32'(sendCode), 32'(sc));
    check(req, "tickOut",  32'(tickOut),  32'(to));
    check(req, "timeOut",  32'(timeOut),  32'(tout));
    check(req, "curCount", 32'(curCount), 32'(cnt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1", 1'b0, 8'h00, 1'b0, 8'h00, 6'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].tk, VECS[i].md, VECS[i].ec, VECS[i].rv, VECS[i].rc);
      checkAll($sformatf("R%0d", VECS[i].req), VECS[i].sr, VECS[i].sc,
               VECS[i].to, VECS[i].tout, VECS[i].cnt);
    end

    // R3: step the counter from 19 up to 63, then across the wrap
    for (int i = 0; i < 44; i++) apply(1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R3", "curCount before wrap", 32'(curCount), 32'd63);
    apply(1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    checkAll("R3", 1'b1, 8'h00, 1'b0, 8'hD3, 6'd0);

    // R3: received successor of 63 is 0
    apply(1'b0, 1'b0, 8'h00, 1'b1, 8'h3F);
    checkAll("R6", 1'b0, 8'h00, 1'b0, 8'hD3, 6'd63);
    apply(1'b0, 1'b0, 8'h00, 1'b1, 8'h40);
    checkAll("R3", 1'b0, 8'h00, 1'b1, 8'h40, 6'd0);

    // R10: one request per tick, even with ticks back to back
    apply(1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    apply(1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R10", "sendReq second tick", 32'(sendReq), 32'd1);
    apply(1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R10", "sendReq after ticks", 32'(sendReq), 32'd0);
    check("R2", "curCount after two ticks", 32'(curCount), 32'd2);

    // R1: reset in the middle of a run
    rstN = 1'b0;
    #1;
    checkAll("R1", 1'b0, 8'h00, 1'b0, 8'h00, 6'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule